// File: doc/BRIEF.md
# Dual-Lane Serial Field Delay Memory

This block stores a video field and plays it back later, so it acts as a digital delay line whose length is set by when the two ports are sent back to address zero. Storage, the write port and the read port are built once per lane, and there are two lanes of 8 bits by default. The lanes share one write clock and one read clock, so they can be used together as a 16-bit path. The two clocks are independent of each other. Each lane has its own pointer-reset and enable controls on both ports.

Each port keeps an address pointer that counts up and wraps. A zeroing request puts the pointer back to zero. A small state machine on each port watches how the zeroing request is sequenced and flags a request that comes too soon after the last one. Each port has two enables. One stops the address from advancing. The other only masks the data, and the address keeps counting. Masking writes lets chosen regions of a field be overwritten while the rest stays intact. A shared mode input sets whether write data is captured in the same cycle as its controls or one cycle later.

Top module: `dual_lane_field_delay`

## Requirements
- R1: A rising edge of a port's clock at which that lane's zeroing input (`wzero`/`rzero`, active high) is sampled high sets that lane's pointer on that port to address 0. The next access on that port uses address 0.
- R2: In a zeroing cycle, the other inputs of that lane on that port are ignored. No word is stored. The read data register keeps its value. `rvalid` keeps its previous level.
- R3: After a zeroing request goes low, it must stay low for at least two clock edges of its port before it goes high again. If it goes high after only one low edge, the lane's `wguard_err`/`rguard_err` bit is high for exactly one cycle after that edge. The request is still carried out. A legal sequence never raises the error bit.
- R4: When `wen` and `ien` are both high (and the lane is not zeroing), the word is stored at the write pointer and the pointer advances.
- R5: When `wen` is high and `ien` is low, the write pointer advances and the addressed word keeps its old contents.
- R6: When `wen` is low, the write pointer holds and nothing is stored, whatever the level of `ien`.
- R7: When `ren` is sampled high at a read edge, the lane's data register loads the word at the read pointer and the pointer advances. When `ren` is sampled low, the pointer and the data register both hold.
- R8: `rvalid` for a lane follows the `oen` level sampled at the previous read edge. While `rvalid` is low, that lane's `rdata` byte is 0. `oen` does not affect the read pointer. All outputs are 0 after `arst_n`.
- R9: With `wmode` = 0, the data present at the control edge is stored. With `wmode` = 1, the data present at the next write edge is stored at the address chosen at the control edge. That write completes even if the controls change in that next cycle.
- R10: Both pointers wrap from address DEPTH-1 to address 0.
- R11: The lanes are independent. The controls of one lane never change the other lane's storage, pointers or outputs. Lane n uses bits [8n+7:8n] of the data buses and bit n of the control buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock, shared by all lanes |
| rclk | input | 1 | Read clock, shared by all lanes |
| arst_n | input | 1 | Asynchronous active-low reset of all registers |
| wmode | input | 1 | Write capture timing: 0 same cycle, 1 next cycle |
| wzero | input | LANES | Per-lane write pointer zeroing request |
| wen | input | LANES | Per-lane write advance enable |
| ien | input | LANES | Per-lane write data enable (mask) |
| wdata | input | LANES*WIDTH | Write data, one byte per lane |
| rzero | input | LANES | Per-lane read pointer zeroing request |
| ren | input | LANES | Per-lane read advance enable |
| oen | input | LANES | Per-lane output enable |
| rdata | output | LANES*WIDTH | Read data, 0 while the lane is not valid |
| rvalid | output | LANES | Per-lane output valid |
| wguard_err | output | LANES | Per-lane one-cycle pulse for a write zeroing request that came too early |
| rguard_err | output | LANES | Per-lane one-cycle pulse for a read zeroing request that came too early |

## Verification
Two things can land on the same edge: a zeroing request, and an access that the enables ask for. The bench raises `wzero` together with `wen` and `ien` while the bus carries a marker byte. It then checks on readback that address 0 holds the first real word and not the marker. On the read side it raises `rzero` together with `ren` and `oen`, and checks that `rvalid` and `rdata` stay at their earlier values. A second clash is an early zeroing request. The bench sends a request after only one low edge and checks that the error bit pulses for exactly one cycle. It then sends a request after a legal gap and checks that no error appears.

// File: rtl/fdl_pkg.sv
package fdl_pkg;

    // Sequencing states of a pointer-zeroing request on one port.
    typedef enum logic [1:0] {
        ZG_ARMED = 2'd0,   // request low long enough; a new one is legal
        ZG_HELD  = 2'd1,   // request currently high
        ZG_GAP   = 2'd2    // one low edge seen since the request dropped
    } zguard_state_e;

endpackage

// File: rtl/fdl_zero_guard.sv
module fdl_zero_guard
    import fdl_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic zero_req,
    output logic early_err
);

    zguard_state_e state_q;
    zguard_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ZG_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: take, stretch, release, settle, early
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ZG_ARMED: state_d = zero_req ? ZG_HELD : ZG_ARMED;  // take
            ZG_HELD:  state_d = zero_req ? ZG_HELD : ZG_GAP;    // stretch / release
            ZG_GAP:   state_d = zero_req ? ZG_HELD : ZG_ARMED;  // early / settle
            default:  state_d = ZG_ARMED;
        endcase
    end

    // Output: pulse when a request re-arrives after a single low edge
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            early_err <= 1'b0;
        end else begin
            early_err <= (state_q == ZG_GAP) && zero_req;
        end
    end

endmodule

// File: rtl/fdl_lane_ram.sv
module fdl_lane_ram #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             arst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdat,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rq
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdat;
        end
    end

    always_ff @(posedge rclk or negedge arst_n) begin
        if (!arst_n) begin
            rq <= '0;
        end else if (re) begin
            rq <= cells[raddr];
        end
    end

endmodule

// File: rtl/fdl_wr_lane.sv
module fdl_wr_lane #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             mode_late,
    input  logic             zero_req,
    input  logic             wen,
    input  logic             ien,
    input  logic [WIDTH-1:0] din,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [WIDTH-1:0] mem_din,
    output logic             guard_err
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_inc;
    logic          pend_q;
    logic [AW-1:0] pend_addr_q;
    logic          live_cycle;

    fdl_zero_guard u_guard (
        .clk       (clk),
        .arst_n    (arst_n),
        .zero_req  (zero_req),
        .early_err (guard_err)
    );

    assign ptr_inc    = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    assign live_cycle = !zero_req && wen;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ptr_q       <= '0;
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else begin
            pend_q      <= mode_late && live_cycle && ien;
            pend_addr_q <= ptr_q;
            if (zero_req) begin
                ptr_q <= '0;
            end else if (wen) begin
                ptr_q <= ptr_inc;
            end
        end
    end

    // Same-cycle capture uses the live pointer; late capture uses the
    // address latched one edge earlier.
    always_comb begin
        if (mode_late) begin
            mem_we   = pend_q;
            mem_addr = pend_addr_q;
        end else begin
            mem_we   = live_cycle && ien;
            mem_addr = ptr_q;
        end
        mem_din = din;
    end

endmodule

// File: rtl/fdl_rd_lane.sv
module fdl_rd_lane #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             zero_req,
    input  logic             ren,
    input  logic             oen,
    input  logic [WIDTH-1:0] ram_q,
    output logic             ram_re,
    output logic [AW-1:0]    ram_addr,
    output logic [WIDTH-1:0] dout,
    output logic             dvalid,
    output logic             guard_err
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] ptr_q;
    logic          oe_q;

    fdl_zero_guard u_guard (
        .clk       (clk),
        .arst_n    (arst_n),
        .zero_req  (zero_req),
        .early_err (guard_err)
    );

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ptr_q <= '0;
            oe_q  <= 1'b0;
        end else if (zero_req) begin
            ptr_q <= '0;
        end else begin
            oe_q <= oen;
            if (ren) begin
                ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    assign ram_re   = !zero_req && ren;
    assign ram_addr = ptr_q;
    assign dvalid   = oe_q;
    assign dout     = oe_q ? ram_q : '0;

endmodule

// File: rtl/dual_lane_field_delay.sv
module dual_lane_field_delay #(
    parameter int LANES = 2,
    parameter int WIDTH = 8,
    parameter int DEPTH = 256
) (
    input  logic                   wclk,
    input  logic                   rclk,
    input  logic                   arst_n,
    input  logic                   wmode,
    input  logic [LANES-1:0]       wzero,
    input  logic [LANES-1:0]       wen,
    input  logic [LANES-1:0]       ien,
    input  logic [LANES*WIDTH-1:0] wdata,
    input  logic [LANES-1:0]       rzero,
    input  logic [LANES-1:0]       ren,
    input  logic [LANES-1:0]       oen,
    output logic [LANES*WIDTH-1:0] rdata,
    output logic [LANES-1:0]       rvalid,
    output logic [LANES-1:0]       wguard_err,
    output logic [LANES-1:0]       rguard_err
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic             m_we;
        logic [AW-1:0]    m_waddr;
        logic [WIDTH-1:0] m_wdat;
        logic             m_re;
        logic [AW-1:0]    m_raddr;
        logic [WIDTH-1:0] m_rq;

        fdl_wr_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_wr (
            .clk       (wclk),
            .arst_n    (arst_n),
            .mode_late (wmode),
            .zero_req  (wzero[g]),
            .wen       (wen[g]),
            .ien       (ien[g]),
            .din       (wdata[g*WIDTH +: WIDTH]),
            .mem_we    (m_we),
            .mem_addr  (m_waddr),
            .mem_din   (m_wdat),
            .guard_err (wguard_err[g])
        );

        fdl_lane_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
            .wclk   (wclk),
            .rclk   (rclk),
            .arst_n (arst_n),
            .we     (m_we),
            .waddr  (m_waddr),
            .wdat   (m_wdat),
            .re     (m_re),
            .raddr  (m_raddr),
            .rq     (m_rq)
        );

        fdl_rd_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_rd (
            .clk       (rclk),
            .arst_n    (arst_n),
            .zero_req  (rzero[g]),
            .ren       (ren[g]),
            .oen       (oen[g]),
            .ram_q     (m_rq),
            .ram_re    (m_re),
            .ram_addr  (m_raddr),
            .dout      (rdata[g*WIDTH +: WIDTH]),
            .dvalid    (rvalid[g]),
            .guard_err (rguard_err[g])
        );
    end

endmodule

// File: rtl/fdl_checks.sv
module fdl_checks #(
    parameter int LANES = 2,
    parameter int WIDTH = 8
) (
    input logic                   wclk,
    input logic                   rclk,
    input logic                   arst_n,
    input logic [LANES-1:0]       wzero,
    input logic [LANES-1:0]       rzero,
    input logic [LANES-1:0]       ren,
    input logic [LANES-1:0]       oen,
    input logic [LANES*WIDTH-1:0] rdata,
    input logic [LANES-1:0]       rvalid,
    input logic [LANES-1:0]       wguard_err,
    input logic [LANES-1:0]       rguard_err
);

    // Set after the first read edge out of reset, so $past never reaches
    // into the reset period.
    logic r_live;
    always_ff @(posedge rclk or negedge arst_n) begin
        if (!arst_n) r_live <= 1'b0;
        else         r_live <= 1'b1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_WERR_NEEDS_REQ: assert property (@(posedge wclk) disable iff (!arst_n)
            wguard_err[g] |-> $past(wzero[g])); // R3
        AST_WERR_ONE_CYCLE: assert property (@(posedge wclk) disable iff (!arst_n)
            wguard_err[g] |=> !wguard_err[g]); // R3
        AST_RERR_NEEDS_REQ: assert property (@(posedge rclk) disable iff (!arst_n)
            rguard_err[g] |-> $past(rzero[g])); // R3
        AST_RERR_ONE_CYCLE: assert property (@(posedge rclk) disable iff (!arst_n)
            rguard_err[g] |=> !rguard_err[g]); // R3
        AST_VALID_FOLLOWS_OE: assert property (@(posedge rclk) disable iff (!arst_n)
            (r_live && !$past(rzero[g])) |-> (rvalid[g] == $past(oen[g]))); // R8
        AST_HOLD_WITHOUT_READ: assert property (@(posedge rclk) disable iff (!arst_n)
            (r_live && $past(!ren[g] || rzero[g]) && $past(rvalid[g]) && rvalid[g])
            |-> $stable(rdata[g*WIDTH +: WIDTH])); // R7
    end

endmodule

bind dual_lane_field_delay fdl_checks #(.LANES(LANES), .WIDTH(WIDTH)) u_fdl_checks (
    .wclk       (wclk),
    .rclk       (rclk),
    .arst_n     (arst_n),
    .wzero      (wzero),
    .rzero      (rzero),
    .ren        (ren),
    .oen        (oen),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .wguard_err (wguard_err),
    .rguard_err (rguard_err)
);

// File: tb/dual_lane_field_delay_test.sv
`timescale 1ns/1ps
module dual_lane_field_delay_test;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        arst_n;
    logic        wmode;
    logic [1:0]  wzero, wen, ien, rzero, ren, oen;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  rvalid, wguard_err, rguard_err;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic [7:0] exp0 [D];
    logic [7:0] exp1 [D];

    always #4 clk = ~clk;   // 125 MHz

    // Both ports run from one bench clock.
    dual_lane_field_delay #(.LANES(2), .WIDTH(8), .DEPTH(D)) uut (
        .wclk       (clk),
        .rclk       (clk),
        .arst_n     (arst_n),
        .wmode      (wmode),
        .wzero      (wzero),
        .wen        (wen),
        .ien        (ien),
        .wdata      (wdata),
        .rzero      (rzero),
        .ren        (ren),
        .oen        (oen),
        .rdata      (rdata),
        .rvalid     (rvalid),
        .wguard_err (wguard_err),
        .rguard_err (rguard_err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int p0, p1, q0, q1;
        logic [7:0] last1;
        arst_n = 1'b0; wmode = 1'b0;
        wzero = '0; wen = '0; ien = '0; wdata = '0;
        rzero = '0; ren = '0; oen = '0;
        repeat (3) tick();
        arst_n = 1'b1;
        tick();
        // Reset state (R8)
        chk("R8 reset rdata", rdata, 16'h0);
        chk("R8 reset rvalid", {14'h0, rvalid}, 16'h0);
        chk("R3 reset errors", {12'h0, wguard_err, rguard_err}, 16'h0);

        // Prefill, same-cycle capture. The zeroing cycle carries a marker
        // byte with both enables high, and that byte must not be stored (R2).
        wzero = 2'b11; wen = 2'b11; ien = 2'b11; wdata = 16'hEEEE;
        tick();
        wzero = 2'b00;
        for (int a = 0; a < D; a++) begin
            wdata = {8'h80 + 8'(a), 8'h40 + 8'(a)};
            exp0[a] = 8'h40 + 8'(a);
            exp1[a] = 8'h80 + 8'(a);
            tick();
        end
        wen = '0; ien = '0;
        tick(); tick();

        // Masked pass running past the end so the pointer wraps (R10).
        // Lane 0 masks every 4th word (R5); lane 1 stalls every 3rd cycle (R6).
        wzero = 2'b11;
        tick();
        wzero = 2'b00;
        p0 = 0; p1 = 0;
        for (int i = 0; i < 20; i++) begin
            wen[0] = 1'b1;
            ien[0] = (i % 4) != 3;
            wen[1] = (i % 3) != 2;
            ien[1] = 1'b1;
            wdata  = {8'hB0 + 8'(i), 8'h10 + 8'(i)};
            if (ien[0]) exp0[p0] = 8'h10 + 8'(i);
            p0 = (p0 + 1) % D;
            if (wen[1]) begin
                exp1[p1] = 8'hB0 + 8'(i);
                p1 = (p1 + 1) % D;
            end
            tick();
        end
        wen = '0; ien = '0;
        tick(); tick();

        // Read zeroing together with ren/oen: the enables are ignored (R2)
        rzero = 2'b11; ren = 2'b11; oen = 2'b11;
        tick();
        chk("R2 rvalid in zeroing cycle", {14'h0, rvalid}, 16'h0);
        chk("R2 rdata in zeroing cycle", rdata, 16'h0);
        rzero = 2'b00;
        q0 = 0; q1 = 0; last1 = 8'h00;
        for (int j = 0; j < 20; j++) begin
            ren[0] = 1'b1;
            oen[0] = (j % 4) != 1;
            ren[1] = (j % 5) != 4;
            oen[1] = 1'b1;
            tick();
            chk("R8 lane0 valid follows oen", {15'h0, rvalid[0]}, {15'h0, oen[0]});
            chk("R1 R4 R5 R9 R10 lane0 word", {8'h0, rdata[7:0]},
                {8'h0, (oen[0] ? exp0[q0] : 8'h00)});
            q0 = (q0 + 1) % D;
            if (ren[1]) begin
                last1 = exp1[q1];
                q1 = (q1 + 1) % D;
            end
            chk("R1 R6 R7 R10 lane1 word", {8'h0, rdata[15:8]}, {8'h0, last1});
        end
        ren = '0; oen = '0;
        tick(); tick();

        // Zeroing request after a single low edge (R3)
        wzero = 2'b01; tick();
        wzero = 2'b00; tick();
        wzero = 2'b01; tick();
        chk("R3 early write zeroing flagged", {14'h0, wguard_err}, 16'h1);
        wzero = 2'b00; tick();
        chk("R3 write error lasts one cycle", {14'h0, wguard_err}, 16'h0);
        tick();
        wzero = 2'b01; tick();
        chk("R3 legal write zeroing not flagged", {14'h0, wguard_err}, 16'h0);
        wzero = 2'b00; tick(); tick();

        rzero = 2'b10; tick();
        rzero = 2'b00; tick();
        rzero = 2'b10; tick();
        chk("R3 R11 early read zeroing flagged", {14'h0, rguard_err}, 16'h2);
        rzero = 2'b00; tick();
        chk("R3 read error lasts one cycle", {14'h0, rguard_err}, 16'h0);
        tick(); tick();

        // Late capture: lane 0 only, lane 1 stays disabled (R9, R11)
        wmode = 1'b1;
        wzero = 2'b01; tick();
        wzero = 2'b00;
        for (int i = 0; i < 4; i++) begin
            wen = 2'b01; ien = 2'b01;
            wdata = {8'h55, 8'h60 + 8'(i)};
            tick();
        end
        wen = '0; ien = '0;
        wdata = {8'h55, 8'h64}; tick();
        wdata = {8'h55, 8'h7F}; tick();
        wmode = 1'b0;
        tick();

        rzero = 2'b11; ren = 2'b11; oen = 2'b11; tick();
        rzero = 2'b00;
        for (int j = 0; j < 6; j++) begin
            tick();
            chk("R9 lane0 late capture", {8'h0, rdata[7:0]},
                {8'h0, (j < 4 ? 8'h61 + 8'(j) : exp0[j])});
            chk("R11 lane1 untouched", {8'h0, rdata[15:8]}, {8'h0, exp1[j]});
        end
        ren = '0; oen = '0;
        tick();
        finish_run();
    end

endmodule